// File: doc/BRIEF.md
# Outbound Address Window Decoder

This block sits on the processor side of a host bridge. It examines every processor-bus address and decides where the access goes. It is claimed by the on-chip register file, forwarded to PCI through one of the programmable windows, or refused. The register file occupies one 64 KiB page. A strap input picks the page, and the block latches the strap when reset is released.

There are four programmable forwarding windows. Each window matches on the upper address half against an inclusive start/end pair. It forms the PCI address by adding a 16-bit offset to that half, and the lower half is copied through. Each window also carries its own read, write and posting enables and a small transfer-attribute code. The decision is registered and presented one clock after the address strobe, together with the translated address and the attributes of the selected window.

Windows are loaded through a simple one-cycle configuration port that writes a whole window at once. The processor-bus handshake, the PCI master and the register contents belong to other blocks.

Top module: `addr_window_decoder`

## Requirements
- R1: The register page is 0xFEFE when `strapHigh` is 0 during reset and 0xFEFF when it is 1. The value held in the last reset cycle is kept until the next reset, and later changes of `strapHigh` have no effect.
- R2: An access to the register page asserts `regHit` only for a transfer size of 1, 2, 3, 4 or 8 bytes. Any other `xferSize` value asserts `accessErr` with no hit.
- R3: An address on the register page is never forwarded, even when a programmable window covers it.
- R4: Window n hits when start(n) <= addr[31:16] <= end(n), with both bounds inclusive.
- R5: On a forward, `pciAddr[31:16]` = (addr[31:16] + offset(n)) mod 2^16 and `pciAddr[15:0]` = addr[15:0].
- R6: When several windows hit, the lowest-numbered one is selected, and `winIdx` gives its number.
- R7: If the selected window has its read enable clear and the access is a read, or its write enable clear and the access is a write, the access is not forwarded and `accessErr` is asserted.
- R8: On a forward, `postEn` and `pciAttr` show the selected window's posting enable and attribute code. Otherwise they are 0.
- R9: `resValid` and all results appear exactly one clock after `addrValid`. Without a strobe, and on a plain miss, `regHit`, `pciHit` and `accessErr` are 0, and `pciAddr`, `winIdx`, `postEn` and `pciAttr` are 0.
- R10: After reset every window is empty (start 0xFFFF, end 0x0000, all enables 0). A configuration write changes only the window named by `cfgWin`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| strapHigh | input | 1 | Register page select strap, latched during reset |
| addrValid | input | 1 | Address strobe |
| addr | input | 32 | Processor-bus address |
| isWrite | input | 1 | 1 = write, 0 = read |
| xferSize | input | 4 | Transfer size in bytes |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWin | input | 2 | Window being configured |
| cfgStart | input | 16 | Window start (upper address half) |
| cfgEnd | input | 16 | Window end (upper address half, inclusive) |
| cfgOffset | input | 16 | Translation offset |
| cfgRdEn | input | 1 | Read enable |
| cfgWrEn | input | 1 | Write enable |
| cfgPostEn | input | 1 | Posting enable |
| cfgAttr | input | 2 | PCI transfer attribute code |
| resValid | output | 1 | Decode result valid |
| regHit | output | 1 | Access claimed by register page |
| pciHit | output | 1 | Access forwarded to PCI |
| winIdx | output | 2 | Selected window |
| pciAddr | output | 32 | Translated address |
| postEn | output | 1 | Selected window posts writes |
| pciAttr | output | 2 | Selected window attribute code |
| accessErr | output | 1 | Illegal register size or permission refusal |

## Verification
Several properties are checked on every cycle: the one-clock result latency, the exclusivity of register claim, forward and error, the lower-half copy of the address, the lowest-window choice and the strap hold after reset. The bench scenarios are needed for the rest. These are the arithmetic of the offset, including the wrap, the inclusive bounds, the permission refusal under overlap, register priority over a covering window, and the strap choice across two resets. The bench compares all of these against a behavioural model on every clock.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  // widest window selector carried in the strobe bundle (up to 16 windows)
  localparam int WIN_SEL_W = 4;

  typedef struct packed {
    logic                 load;      // a decode result is taken this cycle
    logic                 claimReg;  // register page claims the access
    logic                 forward;   // access goes to PCI through winSel
    logic                 flagErr;   // refused access
    logic [WIN_SEL_W-1:0] winSel;    // selected window
  } decStrobe_t;

  function automatic logic sizeLegal(input logic [3:0] sz);
    case (sz)
      4'd1, 4'd2, 4'd3, 4'd4, 4'd8: sizeLegal = 1'b1;
      default:                      sizeLegal = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/win_ctrl.sv
module win_ctrl
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int HALF_W  = 16,
  parameter logic [HALF_W-1:0] PAGE_LOW = 16'hFEFE
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               strapHigh,
  input  logic               addrValid,
  input  logic [HALF_W-1:0]  upAddr,
  input  logic               isWrite,
  input  logic [3:0]         xferSize,
  input  logic [NUM_WIN-1:0] winHitVec,
  input  logic [NUM_WIN-1:0] rdOkVec,
  input  logic [NUM_WIN-1:0] wrOkVec,
  output decStrobe_t         strb
);
  logic strapQ;
  logic [HALF_W-1:0] pageBase;
  logic pageHit;
  logic anyWin;
  logic [WIN_SEL_W-1:0] firstWin;
  logic permOk;

  // strap follows the pin while reset is held and freezes when it lifts
  always_ff @(posedge clk) begin
    if (!rstN) strapQ <= strapHigh;
  end

  assign pageBase = strapQ ? (PAGE_LOW | HALF_W'(1)) : PAGE_LOW;
  assign pageHit  = (upAddr == pageBase);

  // scan downward so the lowest-numbered hitting window is the one kept
  always_comb begin
    anyWin   = 1'b0;
    firstWin = '0;
    permOk   = 1'b0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (winHitVec[i]) begin
        anyWin   = 1'b1;
        firstWin = WIN_SEL_W'(i);
        permOk   = isWrite ? wrOkVec[i] : rdOkVec[i];
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.load     = addrValid;
    strb.winSel   = firstWin;
    if (addrValid) begin
      if (pageHit) begin
        strb.claimReg = sizeLegal(xferSize);
        strb.flagErr  = !sizeLegal(xferSize);
      end else if (anyWin) begin
        strb.forward  = permOk;
        strb.flagErr  = !permOk;
      end
    end
  end

  assert_strap_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> $stable(strapQ));

  assert_one_dest_R3: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strb.claimReg, strb.forward, strb.flagErr}) <= 1);

  assert_lowest_win_R6: assert property (@(posedge clk) disable iff (!rstN)
    strb.forward |-> ((winHitVec & ((NUM_WIN'(1) << strb.winSel) - NUM_WIN'(1))) == '0));

  assert_page_no_fwd_R3: assert property (@(posedge clk) disable iff (!rstN)
    (addrValid && pageHit) |-> !strb.forward);
endmodule

// File: rtl/win_datapath.sv
module win_datapath
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int ADDR_W  = 32,
  parameter int ATTR_W  = 2,
  localparam int HALF_W = ADDR_W / 2,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               cfgWe,
  input  logic [IDX_W-1:0]   cfgWin,
  input  logic [HALF_W-1:0]  cfgStart,
  input  logic [HALF_W-1:0]  cfgEnd,
  input  logic [HALF_W-1:0]  cfgOffset,
  input  logic               cfgRdEn,
  input  logic               cfgWrEn,
  input  logic               cfgPostEn,
  input  logic [ATTR_W-1:0]  cfgAttr,
  input  decStrobe_t         strb,
  output logic [NUM_WIN-1:0] winHitVec,
  output logic [NUM_WIN-1:0] rdOkVec,
  output logic [NUM_WIN-1:0] wrOkVec,
  output logic               resValid,
  output logic               regHit,
  output logic               pciHit,
  output logic [IDX_W-1:0]   winIdx,
  output logic [ADDR_W-1:0]  pciAddr,
  output logic               postEn,
  output logic [ATTR_W-1:0]  pciAttr,
  output logic               accessErr
);
  logic [HALF_W-1:0] startQ  [NUM_WIN];
  logic [HALF_W-1:0] endQ    [NUM_WIN];
  logic [HALF_W-1:0] offQ    [NUM_WIN];
  logic [ATTR_W-1:0] attrQ   [NUM_WIN];
  logic [NUM_WIN-1:0] postQ;

  logic [HALF_W-1:0] upAddr;
  logic [HALF_W-1:0] selOff;
  logic [ATTR_W-1:0] selAttr;
  logic              selPost;
  logic [HALF_W-1:0] xlatUp;

  assign upAddr = addr[ADDR_W-1:HALF_W];

  for (genvar g = 0; g < NUM_WIN; g++) begin : gWin
    always_ff @(posedge clk) begin
      if (!rstN) begin
        startQ[g]  <= '1;
        endQ[g]    <= '0;
        offQ[g]    <= '0;
        attrQ[g]   <= '0;
        postQ[g]   <= 1'b0;
        rdOkVec[g] <= 1'b0;
        wrOkVec[g] <= 1'b0;
      end else if (cfgWe && cfgWin == IDX_W'(g)) begin
        startQ[g]  <= cfgStart;
        endQ[g]    <= cfgEnd;
        offQ[g]    <= cfgOffset;
        attrQ[g]   <= cfgAttr;
        postQ[g]   <= cfgPostEn;
        rdOkVec[g] <= cfgRdEn;
        wrOkVec[g] <= cfgWrEn;
      end
    end
    assign winHitVec[g] = (upAddr >= startQ[g]) && (upAddr <= endQ[g]);
  end

  always_comb begin
    selOff  = '0;
    selAttr = '0;
    selPost = 1'b0;
    for (int i = 0; i < NUM_WIN; i++) begin
      if (strb.winSel == WIN_SEL_W'(i)) begin
        selOff  = offQ[i];
        selAttr = attrQ[i];
        selPost = postQ[i];
      end
    end
  end

  assign xlatUp = upAddr + selOff;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resValid  <= 1'b0;
      regHit    <= 1'b0;
      pciHit    <= 1'b0;
      winIdx    <= '0;
      pciAddr   <= '0;
      postEn    <= 1'b0;
      pciAttr   <= '0;
      accessErr <= 1'b0;
    end else begin
      resValid  <= strb.load;
      regHit    <= strb.load && strb.claimReg;
      pciHit    <= strb.load && strb.forward;
      accessErr <= strb.load && strb.flagErr;
      if (strb.load && strb.forward) begin
        winIdx  <= strb.winSel[IDX_W-1:0];
        pciAddr <= {xlatUp, addr[HALF_W-1:0]};
        postEn  <= selPost;
        pciAttr <= selAttr;
      end else begin
        winIdx  <= '0;
        pciAddr <= '0;
        postEn  <= 1'b0;
        pciAttr <= '0;
      end
    end
  end

  assert_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (resValid == $past(strb.load)));

  assert_err_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    accessErr |-> (!pciHit && !regHit));

  assert_low_copy_R5: assert property (@(posedge clk) disable iff (!rstN)
    pciHit |-> (pciAddr[HALF_W-1:0] == $past(addr[HALF_W-1:0])));

  assert_quiet_miss_R8: assert property (@(posedge clk) disable iff (!rstN)
    !pciHit |-> (!postEn && pciAttr == '0 && pciAddr == '0));
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import addr_win_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter int ADDR_W  = 32,
  parameter int ATTR_W  = 2,
  localparam int HALF_W = ADDR_W / 2,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapHigh,
  input  logic              addrValid,
  input  logic [ADDR_W-1:0] addr,
  input  logic              isWrite,
  input  logic [3:0]        xferSize,
  input  logic              cfgWe,
  input  logic [IDX_W-1:0]  cfgWin,
  input  logic [HALF_W-1:0] cfgStart,
  input  logic [HALF_W-1:0] cfgEnd,
  input  logic [HALF_W-1:0] cfgOffset,
  input  logic              cfgRdEn,
  input  logic              cfgWrEn,
  input  logic              cfgPostEn,
  input  logic [ATTR_W-1:0] cfgAttr,
  output logic              resValid,
  output logic              regHit,
  output logic              pciHit,
  output logic [IDX_W-1:0]  winIdx,
  output logic [ADDR_W-1:0] pciAddr,
  output logic              postEn,
  output logic [ATTR_W-1:0] pciAttr,
  output logic              accessErr
);
  decStrobe_t         strb;
  logic [NUM_WIN-1:0] winHitVec;
  logic [NUM_WIN-1:0] rdOkVec;
  logic [NUM_WIN-1:0] wrOkVec;

  win_ctrl #(.NUM_WIN(NUM_WIN), .HALF_W(HALF_W), .PAGE_LOW(HALF_W'(16'hFEFE))) uCtrl (
    .clk(clk), .rstN(rstN), .strapHigh(strapHigh), .addrValid(addrValid),
    .upAddr(addr[ADDR_W-1:HALF_W]), .isWrite(isWrite), .xferSize(xferSize),
    .winHitVec(winHitVec), .rdOkVec(rdOkVec), .wrOkVec(wrOkVec), .strb(strb)
  );

  win_datapath #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .ATTR_W(ATTR_W)) uPath (
    .clk(clk), .rstN(rstN), .addr(addr),
    .cfgWe(cfgWe), .cfgWin(cfgWin), .cfgStart(cfgStart), .cfgEnd(cfgEnd),
    .cfgOffset(cfgOffset), .cfgRdEn(cfgRdEn), .cfgWrEn(cfgWrEn),
    .cfgPostEn(cfgPostEn), .cfgAttr(cfgAttr), .strb(strb),
    .winHitVec(winHitVec), .rdOkVec(rdOkVec), .wrOkVec(wrOkVec),
    .resValid(resValid), .regHit(regHit), .pciHit(pciHit), .winIdx(winIdx),
    .pciAddr(pciAddr), .postEn(postEn), .pciAttr(pciAttr), .accessErr(accessErr)
  );
endmodule

// File: tb/addr_window_decoder_test.sv
`timescale 1ns/1ps
module addr_window_decoder_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapHigh = 1'b0;
  logic addrValid = 1'b0;
  logic [31:0] addr = '0;
  logic isWrite = 1'b0;
  logic [3:0] xferSize = 4'd4;
  logic cfgWe = 1'b0;
  logic [1:0] cfgWin = '0;
  logic [15:0] cfgStart = '0, cfgEnd = '0, cfgOffset = '0;
  logic cfgRdEn = 1'b0, cfgWrEn = 1'b0, cfgPostEn = 1'b0;
  logic [1:0] cfgAttr = '0;

  logic resValid, regHit, pciHit, postEn, accessErr;
  logic [1:0] winIdx, pciAttr;
  logic [31:0] pciAddr;

  int testsRun = 0;
  int testsFailed = 0;

  always #4 clk = ~clk;

  addr_window_decoder uut (
    .clk(clk), .rstN(rstN), .strapHigh(strapHigh), .addrValid(addrValid),
    .addr(addr), .isWrite(isWrite), .xferSize(xferSize), .cfgWe(cfgWe),
    .cfgWin(cfgWin), .cfgStart(cfgStart), .cfgEnd(cfgEnd), .cfgOffset(cfgOffset),
    .cfgRdEn(cfgRdEn), .cfgWrEn(cfgWrEn), .cfgPostEn(cfgPostEn), .cfgAttr(cfgAttr),
    .resValid(resValid), .regHit(regHit), .pciHit(pciHit), .winIdx(winIdx),
    .pciAddr(pciAddr), .postEn(postEn), .pciAttr(pciAttr), .accessErr(accessErr)
  );

  // behavioural reference model
  int mStart[4], mEnd[4], mOff[4], mAttr[4];
  bit mRd[4], mWr[4], mPost[4];
  bit mStrap;
  logic [41:0] expVec = '0;

  function automatic logic [41:0] modelDecode();
    int up, base, found;
    bit ok;
    logic [41:0] r;
    r = '0;
    if (!addrValid) return r;
    r[41] = 1'b1;
    up = int'(addr[31:16]);
    base = mStrap ? 'hFEFF : 'hFEFE;
    if (up == base) begin
      ok = (xferSize == 1 || xferSize == 2 || xferSize == 3 || xferSize == 4 || xferSize == 8);
      r[40] = ok;
      r[0]  = !ok;
      return r;
    end
    found = -1;
    for (int i = 3; i >= 0; i--)
      if (up >= mStart[i] && up <= mEnd[i]) found = i;
    if (found < 0) return r;
    ok = isWrite ? mWr[found] : mRd[found];
    if (!ok) begin r[0] = 1'b1; return r; end
    r[39]    = 1'b1;
    r[38:37] = 2'(found);
    r[36:5]  = {16'((up + mOff[found]) % 65536), addr[15:0]};
    r[4]     = mPost[found];
    r[3:2]   = 2'(mAttr[found]);
    return r;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mStrap = strapHigh;
      for (int i = 0; i < 4; i++) begin
        mStart[i] = 'hFFFF; mEnd[i] = 0; mOff[i] = 0; mAttr[i] = 0;
        mRd[i] = 0; mWr[i] = 0; mPost[i] = 0;
      end
      expVec = '0;
    end else begin
      expVec = modelDecode();
      if (cfgWe) begin
        mStart[cfgWin] = int'(cfgStart); mEnd[cfgWin] = int'(cfgEnd);
        mOff[cfgWin] = int'(cfgOffset); mAttr[cfgWin] = int'(cfgAttr);
        mRd[cfgWin] = cfgRdEn; mWr[cfgWin] = cfgWrEn; mPost[cfgWin] = cfgPostEn;
      end
    end
  end

  function automatic logic [41:0] actVec();
    return {resValid, regHit, pciHit, winIdx, pciAddr, postEn, pciAttr, 1'b0, accessErr};
  endfunction

  task automatic compare(input string tag);
    testsRun++;
    if (actVec() !== expVec) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, actVec(), expVec);
    end
  endtask

  task automatic checkBit(input string tag, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic checkWord(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model (R9 timing)
  always @(negedge clk) if (rstN) compare("R9 per-cycle");

  task automatic access(input string tag, input logic [31:0] a, input logic w, input logic [3:0] sz);
    @(negedge clk);
    addr = a; isWrite = w; xferSize = sz; addrValid = 1'b1;
    @(negedge clk);
    addrValid = 1'b0;
    compare(tag);
  endtask

  task automatic setWin(input logic [1:0] n, input logic [15:0] s, input logic [15:0] e,
                        input logic [15:0] o, input logic rd, input logic wr,
                        input logic po, input logic [1:0] at);
    @(negedge clk);
    cfgWe = 1'b1; cfgWin = n; cfgStart = s; cfgEnd = e; cfgOffset = o;
    cfgRdEn = rd; cfgWrEn = wr; cfgPostEn = po; cfgAttr = at;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic doReset(input logic strap);
    @(negedge clk);
    rstN = 1'b0; strapHigh = strap;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    strapHigh = !strap;   // must be ignored from here on
  endtask

  task automatic finishRun();
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    doReset(1'b0);
    checkWord("R10 reset outputs", {resValid, regHit, pciHit, accessErr, pciAddr[27:0]}, 32'h0);

    // R1 strap low selects 0xFEFE page
    access("R1 low page", 32'hFEFE_1234, 1'b0, 4'd4);
    checkBit("R1 low page claim", regHit, 1'b1);
    access("R1 other page miss", 32'hFEFF_0000, 1'b0, 4'd4);
    checkBit("R1 other page no claim", regHit, 1'b0);

    // R2 sizes
    access("R2 size3", 32'hFEFE_0010, 1'b1, 4'd3);
    access("R2 size8", 32'hFEFE_0018, 1'b0, 4'd8);
    checkBit("R2 size8 claim", regHit, 1'b1);
    access("R2 size5", 32'hFEFE_0020, 1'b0, 4'd5);
    checkBit("R2 size5 error", accessErr, 1'b1);
    access("R2 size0", 32'hFEFE_0020, 1'b1, 4'd0);

    // R10 empty windows after reset
    access("R10 empty miss", 32'h8000_0000, 1'b0, 4'd4);
    checkBit("R10 empty no error", accessErr, 1'b0);

    // R4 R5 R8 window 0
    setWin(2'd0, 16'h8000, 16'h80FF, 16'h1000, 1'b1, 1'b1, 1'b1, 2'd2);
    access("R4 upper bound", 32'h80FF_ABCD, 1'b1, 4'd4);
    checkWord("R5 translate", pciAddr, 32'h90FF_ABCD);
    checkBit("R8 post", postEn, 1'b1);
    access("R4 lower bound", 32'h8000_0004, 1'b0, 4'd2);
    access("R4 above end", 32'h8100_0000, 1'b0, 4'd4);
    checkBit("R4 above end miss", pciHit, 1'b0);
    access("R4 below start", 32'h7FFF_FFFC, 1'b1, 4'd4);

    // R5 wrap, R8 no posting, R10 isolation
    setWin(2'd1, 16'hF000, 16'hFDFF, 16'h2000, 1'b1, 1'b0, 1'b0, 2'd1);
    access("R5 wrap", 32'hF800_0010, 1'b0, 4'd4);
    checkWord("R5 wrap addr", pciAddr, 32'h1800_0010);
    access("R10 win0 untouched", 32'h8010_0000, 1'b1, 4'd1);

    // R6 overlap
    setWin(2'd2, 16'h8000, 16'h8000, 16'h0000, 1'b1, 1'b1, 1'b0, 2'd3);
    setWin(2'd3, 16'h7000, 16'h9000, 16'h0100, 1'b1, 1'b0, 1'b1, 2'd3);
    access("R6 lowest wins", 32'h8000_0100, 1'b0, 4'd4);
    checkWord("R6 index", {30'd0, winIdx}, 32'd0);
    access("R6 only win3", 32'h9000_0000, 1'b0, 4'd4);
    checkWord("R6 win3 index", {30'd0, winIdx}, 32'd3);

    // R7 permissions
    access("R7 write denied", 32'h9000_0000, 1'b1, 4'd4);
    checkBit("R7 write err", accessErr, 1'b1);
    access("R7 write denied win1", 32'hF100_0000, 1'b1, 4'd4);
    setWin(2'd0, 16'h8000, 16'h80FF, 16'h1000, 1'b0, 1'b1, 1'b1, 2'd2);
    access("R7 read denied on overlap", 32'h8000_0000, 1'b0, 4'd4);
    checkBit("R7 no forward", pciHit, 1'b0);

    // R3 register page priority
    setWin(2'd1, 16'hFE00, 16'hFEFF, 16'h0001, 1'b1, 1'b1, 1'b0, 2'd0);
    access("R3 page over window", 32'hFEFE_0000, 1'b0, 4'd4);
    checkBit("R3 not forwarded", pciHit, 1'b0);
    access("R3 neighbour forwarded", 32'hFEFF_0000, 1'b0, 4'd4);

    // R9 no strobe
    @(negedge clk); addr = 32'hFEFE_0000; addrValid = 1'b0;
    @(negedge clk);
    checkBit("R9 no strobe", regHit | resValid, 1'b0);

    // R1 strap high, then pin change ignored
    doReset(1'b1);
    access("R1 high page", 32'hFEFF_0000, 1'b0, 4'd4);
    checkBit("R1 high page claim", regHit, 1'b1);
    access("R1 low page now miss", 32'hFEFE_0000, 1'b0, 4'd4);
    checkBit("R1 low page no claim", regHit, 1'b0);
    access("R10 windows cleared", 32'h8000_0000, 1'b0, 4'd4);

    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule